// File: doc/BRIEF.md
# Big-Endian Word Load/Store Unit

This unit sits between the load/store stage of a processor and a data memory organized as four byte lanes per word. Each request carries a base register value, a signed 16-bit byte displacement, a store word and a load/store selector. The unit forms the byte address, accepts only addresses that fall on a word boundary, and drives the memory port in the same cycle as the request. Stores put the most significant byte of the register word into the lowest-addressed lane. Loads gather the four lanes back into a register word in the same order.

A request whose byte address is not a multiple of four never reaches the memory. Instead, a one-cycle error pulse is raised and the load result stays at zero. Memory read data arrives one cycle after a read strobe, so load results and error pulses both appear one cycle after the request that caused them. A new request may be issued in every cycle.

Top module: `be_lsu`

## Requirements
- R1: The byte address equals the base value plus the sign-extended 16-bit displacement, modulo 2^32. On an accepted access, `mem_idx_o` equals this address with its two low bits dropped.
- R2: An access is accepted exactly when the two low bits of the byte address are zero. This holds even when neither the base nor the displacement is itself a multiple of four.
- R3: An accepted store raises all four bits of `mem_we_o` in the request cycle and keeps `mem_rd_o` low. Lane k, which sits at `mem_wdata_o[8k+7:8k]` and holds byte address 4*index+k, carries store-data bits [31-8k:24-8k]. So lane 0 carries bits 31:24.
- R4: An accepted load raises `mem_rd_o` in the request cycle with `mem_we_o` at zero. In the next cycle `load_valid_o` is high, and `load_data_o[31-8k:24-8k]` equals read lane k (`mem_rdata_i[8k+7:8k]`).
- R5: A request whose address is not aligned drives neither `mem_rd_o` nor any `mem_we_o` bit. It raises `err_o` for exactly the next cycle, keeps `load_valid_o` low and `load_data_o` at zero, and leaves memory contents unchanged.
- R6: While `rst_ni` is low, and after reset until the first request, `load_valid_o`, `err_o`, `load_data_o`, `mem_rd_o` and `mem_we_o` are all zero.
- R7: A cycle with `req_valid_i` low drives no memory strobe, and in the next cycle `load_valid_o` and `err_o` are low.
- R8: Address arithmetic that overflows past 2^32-1 or underflows below zero wraps around, and the wrapped address is used for both the alignment check and the index.
- R9: Requests in consecutive cycles are served independently. A load issued in the cycle after a store to the same word returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed byte displacement |
| wdata_i | input | 32 | Register word to store |
| mem_idx_o | output | 30 | Word index to memory |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_we_o | output | 4 | Per-lane write enables, bit k = lane k |
| mem_wdata_o | output | 32 | Lane-ordered write data |
| mem_rdata_i | input | 32 | Lane-ordered read data, one cycle after `mem_rd_o` |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Reassembled load word |
| err_o | output | 1 | Misaligned-request pulse |

## Verification
The memory strobes, index and write lanes are combinational in the request cycle, so the driver checks them half a nanosecond after it applies a request and before the next rising edge. Load results and error pulses belong one cycle later. For every request or idle cycle the driver queues one expected response entry. The monitor then pops exactly one entry per rising edge, shortly after that edge, which pins each response to the cycle right after its request. Expected load words come from a byte-level reference image that the driver updates in big-endian order, kept apart from the bench memory model that serves the port.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  typedef enum logic {
    CMD_LOAD  = 1'b0,
    CMD_STORE = 1'b1
  } lsu_cmd_e;

  typedef struct packed {
    logic ld;
    logic err;
  } rsp_flags_t;
endpackage

// File: rtl/be_lsu_agen.sv
module be_lsu_agen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned LANES  = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              aligned_o
);
  localparam int unsigned ALIGN_W = $clog2(LANES);

  logic [ADDR_W-1:0] off_ext;

  assign off_ext   = {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign ea_o      = base_i + off_ext;  // wraps modulo 2^ADDR_W
  assign aligned_o = (ea_o[ALIGN_W-1:0] == '0);
endmodule

// File: rtl/be_lsu_store_lanes.sv
module be_lsu_store_lanes #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] lanes_o
);
  localparam int unsigned LANES = DATA_W / 8;

  // lane k (lowest address first) takes the k-th byte counted from the MSB
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes_o[8*k +: 8] = word_i[DATA_W-1-8*k -: 8];
  end
endmodule

// File: rtl/be_lsu_load_merge.sv
module be_lsu_load_merge #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] lanes_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned LANES = DATA_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word_o[DATA_W-1-8*k -: 8] = en_i ? lanes_i[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/be_lsu.sv
module be_lsu #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 16,
  localparam int unsigned LANES   = DATA_W / 8,
  localparam int unsigned ALIGN_W = $clog2(LANES),
  localparam int unsigned IDX_W   = ADDR_W - ALIGN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic              mem_rd_o,
  output logic [LANES-1:0]  mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              err_o
);
  import be_lsu_pkg::*;

  logic [ADDR_W-1:0] ea;
  logic              aligned;
  lsu_cmd_e          cmd;
  logic              go;
  rsp_flags_t        rsp_d, rsp_q;

  be_lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_agen (
    .base_i    (base_i),
    .offset_i  (offset_i),
    .ea_o      (ea),
    .aligned_o (aligned)
  );

  assign cmd = lsu_cmd_e'(req_store_i);
  assign go  = req_valid_i && aligned;

  assign mem_idx_o = ea[ADDR_W-1:ALIGN_W];
  assign mem_rd_o  = go && (cmd == CMD_LOAD);
  assign mem_we_o  = {LANES{go && (cmd == CMD_STORE)}};

  be_lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
    .word_i  (wdata_i),
    .lanes_o (mem_wdata_o)
  );

  assign rsp_d.ld  = mem_rd_o;
  assign rsp_d.err = req_valid_i && !aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_q <= '0;
    else         rsp_q <= rsp_d;
  end

  be_lsu_load_merge #(.DATA_W(DATA_W)) u_ld (
    .en_i    (rsp_q.ld),
    .lanes_i (mem_rdata_i),
    .word_o  (load_data_o)
  );

  assign load_valid_o = rsp_q.ld;
  assign err_o        = rsp_q.err;
endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 16,
  localparam int unsigned LANES   = DATA_W / 8,
  localparam int unsigned ALIGN_W = $clog2(LANES),
  localparam int unsigned IDX_W   = ADDR_W - ALIGN_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic [IDX_W-1:0]  mem_idx_o,
  input logic              mem_rd_o,
  input logic [LANES-1:0]  mem_we_o,
  input logic              load_valid_o,
  input logic [DATA_W-1:0] load_data_o,
  input logic              err_o
);
  logic [ADDR_W-1:0] ref_ea;
  logic              ref_ok;

  assign ref_ea = base_i + {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign ref_ok = (ref_ea[ALIGN_W-1:0] == '0);

  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || (|mem_we_o)) |-> (mem_idx_o == ref_ea[ADDR_W-1:ALIGN_W])); // R1
  AST_WE_ALL_OR_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o == '0) || (&mem_we_o)); // R3
  AST_STORE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && ref_ok) |-> (&mem_we_o && !mem_rd_o)); // R3
  AST_LOAD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i && ref_ok) |=> (load_valid_o && !err_o)); // R4
  AST_MISALIGN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ref_ok) |-> (!mem_rd_o && mem_we_o == '0)); // R5
  AST_MISALIGN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ref_ok) |=> (err_o && !load_valid_o)); // R5
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (load_data_o == '0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!load_valid_o && !err_o)); // R7
  AST_RD_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && (|mem_we_o))); // R4
endmodule

bind be_lsu be_lsu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_store_i  (req_store_i),
  .base_i       (base_i),
  .offset_i     (offset_i),
  .mem_idx_o    (mem_idx_o),
  .mem_rd_o     (mem_rd_o),
  .mem_we_o     (mem_we_o),
  .load_valid_o (load_valid_o),
  .load_data_o  (load_data_o),
  .err_o        (err_o)
);

// File: tb/be_lsu_tb.sv
`timescale 1ns/100ps
module be_lsu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] offset = '0;
  logic [31:0] wdata = '0;
  logic [29:0] mem_idx;
  logic        mem_rd;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        load_valid;
  logic [31:0] load_data;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed {
    logic        v;
    logic        e;
    logic [31:0] d;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [7:0] bmem[64];     // memory model behind the port
  logic [7:0] ref_mem[64];  // bench reference image

  always #2 clk = ~clk;  // 250 MHz

  be_lsu u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid),
    .req_store_i  (req_store),
    .base_i       (base),
    .offset_i     (offset),
    .wdata_i      (wdata),
    .mem_idx_o    (mem_idx),
    .mem_rd_o     (mem_rd),
    .mem_we_o     (mem_we),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata),
    .load_valid_o (load_valid),
    .load_data_o  (load_data),
    .err_o        (err)
  );

  always @(posedge clk) begin
    if (mem_rd)
      for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] <= bmem[{mem_idx[3:0], 2'(k)}];
    for (int k = 0; k < 4; k++)
      if (mem_we[k]) bmem[{mem_idx[3:0], 2'(k)}] <= mem_wdata[8*k +: 8];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    req_valid = 1'b0;
    #0.5;
    chk({req, " idle rd"}, 32'(mem_rd), 32'd0);
    chk({req, " idle we"}, 32'(mem_we), 32'd0);
    exp_q.push_back('{v: 1'b0, e: 1'b0, d: 32'd0});
    tag_q.push_back(req);
  endtask

  task automatic access(input bit st, input logic [31:0] b, input logic [15:0] o,
                        input logic [31:0] wd, input string req);
    logic [31:0] ea;
    ea = b + {{16{o[15]}}, o};
    @(negedge clk);
    req_valid = 1'b1; req_store = st; base = b; offset = o; wdata = wd;
    #0.5;
    if (ea[1:0] != 2'b00) begin
      chk({req, " misaligned rd"}, 32'(mem_rd), 32'd0);
      chk({req, " misaligned we"}, 32'(mem_we), 32'd0);
      exp_q.push_back('{v: 1'b0, e: 1'b1, d: 32'd0});
    end else if (st) begin
      chk({req, " store idx"}, 32'(mem_idx), 32'(ea[31:2]));
      chk({req, " store we"}, 32'(mem_we), 32'hF);
      chk({req, " store rd"}, 32'(mem_rd), 32'd0);
      chk({req, " store lanes"}, mem_wdata, {wd[7:0], wd[15:8], wd[23:16], wd[31:24]});
      for (int k = 0; k < 4; k++) ref_mem[ea[5:0] + 6'(k)] = wd[31-8*k -: 8];
      exp_q.push_back('{v: 1'b0, e: 1'b0, d: 32'd0});
    end else begin
      chk({req, " load idx"}, 32'(mem_idx), 32'(ea[31:2]));
      chk({req, " load rd"}, 32'(mem_rd), 32'd1);
      chk({req, " load we"}, 32'(mem_we), 32'd0);
      exp_q.push_back('{v: 1'b1, e: 1'b0,
        d: {ref_mem[ea[5:0]], ref_mem[ea[5:0]+6'd1], ref_mem[ea[5:0]+6'd2], ref_mem[ea[5:0]+6'd3]}});
    end
    tag_q.push_back(req);
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " rsp valid"}, 32'(load_valid), 32'(e.v));
        chk({t, " rsp err"}, 32'(err), 32'(e.e));
        chk({t, " rsp data"}, load_data, e.d);
      end
    end
  end

  initial begin : watchdog
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 64; i++) begin
      bmem[i] = 8'hA0 + 8'(i);
      ref_mem[i] = 8'hA0 + 8'(i);
    end
    #1;
    chk("R6 reset valid", 32'(load_valid), 32'd0);
    chk("R6 reset err", 32'(err), 32'd0);
    chk("R6 reset data", load_data, 32'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 post-reset rd", 32'(mem_rd), 32'd0);
    chk("R6 post-reset we", 32'(mem_we), 32'd0);
    chk("R6 post-reset valid", 32'(load_valid), 32'd0);

    access(1'b0, 32'h0000_0008, 16'h0000, '0, "R4 load preload");
    access(1'b1, 32'h0000_0100, 16'h0010, 32'h1122_3344, "R3 store +off");
    access(1'b0, 32'h0000_0110, 16'h0000, '0, "R9 load after store");
    access(1'b1, 32'h0000_0040, 16'hFFF4, 32'hDEAD_BEEF, "R1 store -off");
    idle("R7");
    access(1'b0, 32'h0000_0030, 16'h0004, '0, "R1 load back");
    access(1'b0, 32'hFFFF_FFFC, 16'h0008, '0, "R8 overflow wrap");
    access(1'b1, 32'h0000_0004, 16'hFFF8, 32'hCAFE_F00D, "R8 underflow wrap");
    access(1'b0, 32'h0000_0000, 16'hFFFC, '0, "R8 load wrapped");
    access(1'b0, 32'h0000_0001, 16'h0003, '0, "R2 split-low-bits aligned");
    access(1'b1, 32'h0000_0002, 16'h0000, 32'h5555_AAAA, "R5 misaligned store");
    access(1'b0, 32'h0000_0000, 16'h0000, '0, "R5 memory untouched");
    access(1'b0, 32'h0000_0008, 16'h0001, '0, "R5 misaligned load");
    access(1'b0, 32'h0000_0010, 16'hFFFF, '0, "R2 misaligned -1");
    access(1'b0, 32'h0000_0023, 16'h0002, '0, "R5 misaligned +2");
    idle("R7 after error");
    access(1'b1, 32'h0000_0020, 16'h0000, 32'h0102_0304, "R9 b2b store");
    access(1'b0, 32'h0000_0006, 16'h0000, '0, "R9 b2b misaligned");
    access(1'b0, 32'h0000_0020, 16'h0000, '0, "R9 b2b load");
    access(1'b1, 32'h0000_0024, 16'h0000, 32'h8000_00FF, "R3 msb lane");
    access(1'b0, 32'h0000_0024, 16'h0000, '0, "R4 msb lane back");
    idle("R7 drain");
    idle("R7 drain2");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule